// File: doc/BRIEF.md
# Serial Transmit Output Control

This block sits beside the serial transmit drivers of a multi-channel transceiver. Each channel has two drivers. The block decides, cycle by cycle, what each driver's output pin carries and whether that driver is powered down. It also says whether a channel's internal logic may be powered down, and it flags a channel that has just come back from being fully off.

Software writes the two enable bits of a channel through a small write port. The port carries a channel address and a two-bit data field. An enabled driver passes its shifter bit to the pin, or a constant 1 while the channel is in local loopback. This keeps diagnostic traffic off the line. A disabled driver idles at 0 and asserts its power-down output. The block does not model analog behaviour such as output swing or coupling.

When a channel that had both drivers off gets at least one driver enabled, a settling counter starts. The channel's settling flag then stays high for a programmable number of cycles. During that window the outputs are not yet trustworthy.

Top module: `txDriveCtrl`

## Requirements
- R1: A write with `cfgWrEn` high and `cfgAddr` equal to channel c loads `cfgData` into that channel's enables at the next rising edge. Bit 0 enables driver 0 (pin index 2c) and bit 1 enables driver 1 (pin index 2c+1). Other channels keep their enables.
- R2: A disabled driver holds its `drvPwrDn` bit high and drives 0 on its `serOut` bit. An enabled driver holds `drvPwrDn` low.
- R3: `chPwrDn[c]` is high exactly when both drivers of channel c are disabled.
- R4: If `rstN` is sampled low at a rising edge, every driver enable and every settling counter is cleared. All drivers are then powered down and no settling flag is set.
- R5: With `loopEn[c]` low, an enabled driver at pin index i outputs `shiftData[i]`.
- R6: With `loopEn[c]` high, each enabled driver of channel c outputs a constant 1 whatever `shiftData` holds. A disabled driver still outputs 0.
- R7: A write that takes a channel from both drivers disabled to at least one enabled raises `settling[c]` for exactly `SETTLE_CYCLES` consecutive cycles, starting after the edge that applies the write.
- R8: A write to a channel that already has a driver enabled does not restart its settling window. Disabling the channel during the window does not stop the count either.
- R9: A write of 00 to a fully disabled channel leaves its settling flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, sampled on the rising edge |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | CH_AW | Channel selected by the write |
| cfgData | input | 2 | Driver enables for the selected channel |
| loopEn | input | NUM_CH | Per-channel local loopback |
| shiftData | input | 2*NUM_CH | Transmit shifter bit for each driver |
| serOut | output | 2*NUM_CH | Bit driven on each serial output |
| drvPwrDn | output | 2*NUM_CH | Per-driver power-down |
| chPwrDn | output | NUM_CH | Channel logic power-down |
| settling | output | NUM_CH | Channel recently re-enabled, outputs not yet valid |

## Verification
Two events can fall in the same cycle: reset being sampled low, and a configuration write that re-enables a fully disabled channel. When they coincide, the reset must win, so the channel stays powered down and does not start a settling window. The bench drives a re-enabling write while `rstN` is low, and also drives a write in the last cycle of a running window. The reference model, updated at every edge, must agree on `settling` and `drvPwrDn` in both cases.

// File: rtl/txDrivePkg.sv
package txDrivePkg;
  // Strobes handed from the control side to the output datapath, one set per channel.
  typedef struct packed {
    logic [1:0] drvOn;    // driver enables
    logic       forceOne; // loopback: enabled drivers send constant 1
  } chCtl_t;
endpackage

// File: rtl/txDriveCfg.sv
module txDriveCfg
  import txDrivePkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int SETTLE_CYCLES = 20,
  localparam int CH_AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic [CH_AW-1:0]          cfgAddr,
  input  logic [1:0]                cfgData,
  input  logic [NUM_CH-1:0]         loopEn,
  output chCtl_t [NUM_CH-1:0]       ctl,
  output logic [NUM_CH-1:0]         chPwrDn,
  output logic [NUM_CH-1:0]         settling
);

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic [1:0]       enQ;
    logic [SET_W-1:0] cntQ;
    logic             hit;
    logic             wake;

    assign hit  = cfgWrEn && (cfgAddr == CH_AW'(c));
    assign wake = hit && (enQ == 2'b00) && (cfgData != 2'b00);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ  <= 2'b00;
        cntQ <= '0;
      end else begin
        if (hit) enQ <= cfgData;
        if (wake)             cntQ <= SET_W'(SETTLE_CYCLES);
        else if (cntQ != '0)  cntQ <= cntQ - 1'b1;
      end
    end

    assign ctl[c].drvOn    = enQ;
    assign ctl[c].forceOne = loopEn[c];
    assign chPwrDn[c]      = (enQ == 2'b00);
    assign settling[c]     = (cntQ != '0);
  end

endmodule

// File: rtl/txDriveLanes.sv
module txDriveLanes
  import txDrivePkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int NUM_DRV = 2 * NUM_CH
) (
  input  chCtl_t [NUM_CH-1:0] ctl,
  input  logic [NUM_DRV-1:0]  shiftData,
  output logic [NUM_DRV-1:0]  serOut,
  output logic [NUM_DRV-1:0]  drvPwrDn
);

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    for (genvar d = 0; d < 2; d++) begin : gDrv
      localparam int IDX = 2 * c + d;
      assign drvPwrDn[IDX] = ~ctl[c].drvOn[d];
      assign serOut[IDX]   = ctl[c].drvOn[d] & (ctl[c].forceOne | shiftData[IDX]);
    end
  end

endmodule

// File: rtl/txDriveCtrl.sv
module txDriveCtrl
  import txDrivePkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int SETTLE_CYCLES = 20,
  localparam int CH_AW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int NUM_DRV = 2 * NUM_CH
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [CH_AW-1:0]   cfgAddr,
  input  logic [1:0]         cfgData,
  input  logic [NUM_CH-1:0]  loopEn,
  input  logic [NUM_DRV-1:0] shiftData,
  output logic [NUM_DRV-1:0] serOut,
  output logic [NUM_DRV-1:0] drvPwrDn,
  output logic [NUM_CH-1:0]  chPwrDn,
  output logic [NUM_CH-1:0]  settling
);

  chCtl_t [NUM_CH-1:0] ctl;

  txDriveCfg #(.NUM_CH(NUM_CH), .SETTLE_CYCLES(SETTLE_CYCLES)) cfg_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .loopEn(loopEn), .ctl(ctl),
    .chPwrDn(chPwrDn), .settling(settling)
  );

  txDriveLanes #(.NUM_CH(NUM_CH)) lanes_i (
    .ctl(ctl), .shiftData(shiftData), .serOut(serOut), .drvPwrDn(drvPwrDn)
  );

endmodule

// File: rtl/txDriveCtrlChk.sv
module txDriveCtrlChk #(
  parameter int NUM_CH        = 4,
  parameter int SETTLE_CYCLES = 20,
  localparam int CH_AW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int NUM_DRV = 2 * NUM_CH
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWrEn,
  input logic [CH_AW-1:0]   cfgAddr,
  input logic [1:0]         cfgData,
  input logic [NUM_CH-1:0]  loopEn,
  input logic [NUM_DRV-1:0] shiftData,
  input logic [NUM_DRV-1:0] serOut,
  input logic [NUM_DRV-1:0] drvPwrDn,
  input logic [NUM_CH-1:0]  chPwrDn,
  input logic [NUM_CH-1:0]  settling
);

  // R4: a sampled reset leaves everything powered down and quiet
  a_r4_reset_clears: assert property (@(posedge clk)
    !rstN |=> (&drvPwrDn) && (settling == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    // R1: written enables appear one edge later
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWrEn && cfgAddr == CH_AW'(c)) |=> (drvPwrDn[2*c +: 2] == ~$past(cfgData)));

    // R3: channel power-down tracks its pair of drivers
    a_r3_ch_pwrdn: assert property (@(posedge clk) disable iff (!rstN)
      chPwrDn[c] == (drvPwrDn[2*c] && drvPwrDn[2*c+1]));

    // R7: leaving the fully-off state opens a settling window
    a_r7_settle_starts: assert property (@(posedge clk) disable iff (!rstN)
      $fell(chPwrDn[c]) |-> settling[c]);

    for (genvar d = 0; d < 2; d++) begin : gDrv
      // R2: powered-down driver idles at 0
      a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
        drvPwrDn[2*c+d] |-> !serOut[2*c+d]);

      // R6: loopback forces 1 on an enabled driver
      a_r6_loop_one: assert property (@(posedge clk) disable iff (!rstN)
        (loopEn[c] && !drvPwrDn[2*c+d]) |-> serOut[2*c+d]);

      // R5: normal path follows shifter data
      a_r5_pass_data: assert property (@(posedge clk) disable iff (!rstN)
        (!loopEn[c] && !drvPwrDn[2*c+d]) |-> (serOut[2*c+d] == shiftData[2*c+d]));
    end
  end

endmodule

bind txDriveCtrl txDriveCtrlChk #(.NUM_CH(NUM_CH), .SETTLE_CYCLES(SETTLE_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
  .loopEn(loopEn), .shiftData(shiftData), .serOut(serOut), .drvPwrDn(drvPwrDn),
  .chPwrDn(chPwrDn), .settling(settling)
);

// File: tb/txDriveCtrl_tb_top.sv
module txDriveCtrl_tb_top;
  localparam int NCH    = 4;
  localparam int SETTLE = 20;
  localparam int AW     = 2;
  localparam int ND     = 2 * NCH;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgWrEn;
  logic [AW-1:0] cfgAddr;
  logic [1:0]    cfgData;
  logic [NCH-1:0] loopEn;
  logic [ND-1:0]  shiftData;
  logic [ND-1:0]  serOut, drvPwrDn;
  logic [NCH-1:0] chPwrDn, settling;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int mEn [NCH];
  int mCnt[NCH];

  always #5 clk = ~clk;

  txDriveCtrl dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .loopEn(loopEn), .shiftData(shiftData), .serOut(serOut), .drvPwrDn(drvPwrDn),
    .chPwrDn(chPwrDn), .settling(settling)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin mEn[c] = 0; mCnt[c] = 0; end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (mCnt[c] > 0) mCnt[c]--;
        if (cfgWrEn && cfgAddr == c) begin
          if (mEn[c] == 0 && cfgData != 0) mCnt[c] = SETTLE;
          mEn[c] = cfgData;
        end
      end
    end
  endtask

  task automatic compareAll();
    logic [ND-1:0] eOut, ePd;
    logic [NCH-1:0] eCh, eSet;
    for (int c = 0; c < NCH; c++) begin
      for (int d = 0; d < 2; d++) begin
        bit on;
        on = mEn[c][d];
        ePd[2*c+d]  = !on;
        eOut[2*c+d] = on && (loopEn[c] || shiftData[2*c+d]);
      end
      eCh[c]  = (mEn[c] == 0);
      eSet[c] = (mCnt[c] > 0);
    end
    check("R2 R5 R6 serOut", serOut, eOut);
    check("R1 R2 R4 drvPwrDn", drvPwrDn, ePd);
    check("R3 chPwrDn", chPwrDn, eCh);
    check("R7 R8 R9 settling", settling, eSet);
  endtask

  task automatic cyc();
    @(posedge clk);
    modelEdge();
    #2;
    compareAll();
  endtask

  task automatic wr(input int ch, input int data);
    cfgWrEn = 1'b1; cfgAddr = AW'(ch); cfgData = 2'(data);
    cyc();
    cfgWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      shiftData = ND'($urandom);
      cyc();
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hiCount;
    for (int c = 0; c < NCH; c++) begin mEn[c] = 0; mCnt[c] = 0; end
    rstN = 1'b0; cfgWrEn = 1'b0; cfgAddr = '0; cfgData = '0;
    loopEn = '0; shiftData = '0;
    idle(3);
    // R4: reset state
    check("R4 reset all powered down", drvPwrDn, {ND{1'b1}});
    check("R4 reset no settling", settling, 0);
    rstN = 1'b1;
    idle(1);

    // R1 R7: enable driver 0 of channel 0 and time the window
    wr(0, 1);
    hiCount = 0;
    if (settling[0]) hiCount++;
    for (int i = 0; i < SETTLE + 3; i++) begin
      shiftData = ND'($urandom);
      cyc();
      if (settling[0]) hiCount++;
    end
    check("R7 settling duration", hiCount, SETTLE);

    // R5 data passes; R6 loopback forces one
    shiftData = 8'h00; loopEn = 4'b0001; cyc();
    check("R6 loopback drives 1", serOut[0], 1);
    check("R6 disabled stays 0 in loopback", serOut[1], 0);
    loopEn = 4'b0000; shiftData = 8'hFF; cyc();
    check("R5 data passes", serOut[0], 1);

    // R8: second write while already enabled, mid-window writes
    wr(1, 2);
    idle(5);
    wr(1, 3);
    idle(3);
    wr(1, 0);          // disable during window: count keeps going
    idle(4);
    wr(1, 1);          // re-enable restarts
    idle(2);

    // R9: 00 to a fully-off channel
    wr(2, 0);
    check("R9 no settling on zero write", settling[2], 0);
    idle(2);

    // collision: re-enabling write while reset is sampled low
    wr(3, 2);
    wr(3, 0);
    rstN = 1'b0; cfgWrEn = 1'b1; cfgAddr = 2'd3; cfgData = 2'd3;
    cyc();
    cfgWrEn = 1'b0; rstN = 1'b1;
    check("R4 reset wins over write", chPwrDn[3], 1);
    check("R4 reset clears settling", settling, 0);
    idle(2);

    // write landing in the last cycle of a window
    wr(2, 1);
    idle(SETTLE - 1);
    wr(2, 3);
    idle(3);

    // random phase
    for (int i = 0; i < 600; i++) begin
      shiftData = ND'($urandom);
      loopEn    = NCH'($urandom);
      cfgWrEn   = ($urandom % 4) == 0;
      cfgAddr   = AW'($urandom);
      cfgData   = 2'($urandom);
      rstN      = ($urandom % 97) != 0;
      cyc();
    end
    cfgWrEn = 1'b0; rstN = 1'b1;
    idle(SETTLE + 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule